// File: doc/BRIEF.md
# UART Command Decoder and Reply Arbiter

This block sits behind a UART byte receiver and in front of a UART byte transmitter. It turns the received byte stream into configuration writes and reply requests. Six command codes take one following argument byte and load a configuration register. Two command codes take no argument and ask for a reply packet, either a status packet or a ping packet. Register writes are never acknowledged, so the transmit line carries only replies and trace packets.

One transmit byte stream is shared by the reply packets and by four-byte trace packets offered from outside. The block decides which packet goes next. It then sends that packet's bytes in order, with a valid/ready handshake toward the transmitter. Once a packet has started, it runs to its end before any other packet can begin. The block also keeps a sticky flag that records a framing error on receive.

Top module: `cmd_link`

## Requirements
- R1: The two-byte commands load registers on the clock edge that accepts the argument byte. 0x10 loads `trace_mask` with all 8 bits. 0x11 loads `trace_div` with argument bits 3:0. 0x20 loads `pat_mode` with bits 2:0. 0x21 loads `pat_div` with bits 5:0. 0x22 loads `pat_a` with all 8 bits.
- R2: Command 0x12 loads `arm` from argument bit 0 and `stream_en` from bit 1. Argument bit 2 raises `clr_pulse` and bit 3 raises `snap_pulse`, each for exactly one cycle.
- R3: A register-write command produces no byte on the transmit stream.
- R4: Byte 0x30, received where a command is expected, queues a status packet: 0xA5, status, `event_count`, `drop_count`.
- R5: Byte 0x31, received where a command is expected, queues a ping packet: 0xD7, 0x54, 0x01, status.
- R6: The status byte is taken when its packet is loaded. Bit 7 is `trace_overflow`, bit 6 is `rx_err`, bit 5 is `trace_pending`, bit 4 is `stream_en`, bit 3 is `arm`, and bits 2:0 are `pat_mode`.
- R7: A byte other than 0x10, 0x11, 0x12, 0x20, 0x21, 0x22, 0x30 or 0x31, received where a command is expected, changes nothing. The byte after it is decoded as a command.
- R8: A byte received with `rx_ferr` high is discarded, sets `rx_err`, and returns the decoder to waiting for a command. `rx_err` stays high until a 0x12 write with bit 2 set clears it.
- R9: Once a packet has started, all four of its bytes are sent before another packet starts. A byte is held stable while `tx_ready` is low.
- R10: When the transmitter is free, a trace request wins over the replies, and a status reply wins over a ping. `trace_take` is high in the cycle the trace packet is accepted. The trace packet is then sent starting from `trace_pkt[31:24]`.
- R11: An argument byte is stored as data even when its value equals a command code. It queues no packet.
- R12: After reset, all configuration registers, `rx_err`, the pulses and `tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_data` is valid this cycle |
| rx_ferr | input | 1 | The byte being received had a framing error |
| trace_pending | input | 1 | The trace side holds an event not yet sent |
| trace_overflow | input | 1 | The trace side has dropped an event |
| event_count | input | 8 | Count of trace events |
| drop_count | input | 8 | Count of dropped trace events |
| trace_req | input | 1 | A trace packet is offered |
| trace_pkt | input | 32 | Trace packet, first byte in bits 31:24 |
| trace_take | output | 1 | The offered trace packet is accepted this cycle |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | The transmitter accepts `tx_data` |
| trace_mask | output | 8 | Trace change mask |
| trace_div | output | 4 | Trace sample divider |
| arm | output | 1 | Tracing armed |
| stream_en | output | 1 | Trace streaming enabled |
| clr_pulse | output | 1 | One-cycle clear of counters and errors |
| snap_pulse | output | 1 | One-cycle snapshot request |
| pat_mode | output | 3 | Pattern mode |
| pat_div | output | 6 | Pattern update divider |
| pat_a | output | 8 | Pattern value A |
| rx_err | output | 1 | Sticky framing-error flag |

## Verification
A table of register writes uses arguments with their upper bits set. This shows that the divider and mode fields keep only their low bits, while the mask and pattern value keep all eight. Some byte sequences put a command code in an argument position, and others put an unknown code or a framing-errored byte before a real command. These show whether the decoder keeps track of where it is in a command. Status and ping requests are sent with different flag inputs, and the sticky error is set and then cleared, so each bit of the status byte is exercised. A final run holds `tx_ready` low while a status packet, a ping request and a trace request are all waiting. It then checks the order of the twelve bytes sent, which tells apart priority, packet completion and stalling.

// File: rtl/cmd_link.sv
module cmd_link (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  input  logic        rx_ferr,
  input  logic        trace_pending,
  input  logic        trace_overflow,
  input  logic [7:0]  event_count,
  input  logic [7:0]  drop_count,
  input  logic        trace_req,
  input  logic [31:0] trace_pkt,
  output logic        trace_take,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  trace_mask,
  output logic [3:0]  trace_div,
  output logic        arm,
  output logic        stream_en,
  output logic        clr_pulse,
  output logic        snap_pulse,
  output logic [2:0]  pat_mode,
  output logic [5:0]  pat_div,
  output logic [7:0]  pat_a,
  output logic        rx_err
);
  localparam logic [7:0] C_MASK = 8'h10, C_TDIV = 8'h11, C_CTRL = 8'h12;
  localparam logic [7:0] C_MODE = 8'h20, C_PDIV = 8'h21, C_PVAL = 8'h22;
  localparam logic [7:0] C_STAT = 8'h30, C_PING = 8'h31;

  logic       in_arg;
  logic [7:0] cmd_q;
  logic       want_stat, want_ping;
  logic       busy;
  logic [1:0] idx;
  logic [31:0] sh;

  wire rx_ok   = rx_valid & ~rx_ferr;
  wire cmd_ok  = rx_ok & ~in_arg;
  wire two_byte = (rx_data == C_MASK) || (rx_data == C_TDIV) || (rx_data == C_CTRL) ||
                  (rx_data == C_MODE) || (rx_data == C_PDIV) || (rx_data == C_PVAL);
  wire [7:0] status = {trace_overflow, rx_err, trace_pending, stream_en, arm, pat_mode};
  wire go_stat = ~busy & ~trace_req & want_stat;
  wire go_ping = ~busy & ~trace_req & ~want_stat & want_ping;

  assign trace_take = ~busy & trace_req;
  assign tx_valid   = busy;
  assign tx_data    = sh[31:24];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_arg <= 1'b0;  cmd_q <= '0;
      trace_mask <= '0; trace_div <= '0; arm <= 1'b0; stream_en <= 1'b0;
      clr_pulse <= 1'b0; snap_pulse <= 1'b0;
      pat_mode <= '0; pat_div <= '0; pat_a <= '0; rx_err <= 1'b0;
    end else begin
      clr_pulse  <= 1'b0;
      snap_pulse <= 1'b0;
      if (rx_valid && rx_ferr) begin
        rx_err <= 1'b1;
        in_arg <= 1'b0;
      end else if (rx_ok && in_arg) begin
        in_arg <= 1'b0;
        case (cmd_q)
          C_MASK: trace_mask <= rx_data;
          C_TDIV: trace_div  <= rx_data[3:0];
          C_MODE: pat_mode   <= rx_data[2:0];
          C_PDIV: pat_div    <= rx_data[5:0];
          C_PVAL: pat_a      <= rx_data;
          C_CTRL: begin
            arm        <= rx_data[0];
            stream_en  <= rx_data[1];
            clr_pulse  <= rx_data[2];
            snap_pulse <= rx_data[3];
            if (rx_data[2]) rx_err <= 1'b0;
          end
          default: ;
        endcase
      end else if (cmd_ok && two_byte) begin
        in_arg <= 1'b1;
        cmd_q  <= rx_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      want_stat <= 1'b0;
      want_ping <= 1'b0;
    end else begin
      want_stat <= (want_stat & ~go_stat) | (cmd_ok & (rx_data == C_STAT));
      want_ping <= (want_ping & ~go_ping) | (cmd_ok & (rx_data == C_PING));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; idx <= '0; sh <= '0;
    end else if (!busy) begin
      idx <= '0;
      if (trace_req) begin
        busy <= 1'b1; sh <= trace_pkt;
      end else if (want_stat) begin
        busy <= 1'b1; sh <= {8'hA5, status, event_count, drop_count};
      end else if (want_ping) begin
        busy <= 1'b1; sh <= {8'hD7, 8'h54, 8'h01, status};
      end
    end else if (tx_ready) begin
      sh  <= {sh[23:0], 8'h00};
      idx <= idx + 2'd1;
      if (idx == 2'd3) busy <= 1'b0;
    end
  end
endmodule

module cmd_link_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        rx_ferr,
  input logic        trace_take,
  input logic [31:0] trace_pkt,
  input logic [7:0]  tx_data,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        clr_pulse,
  input logic        snap_pulse,
  input logic        rx_err
);
  p_pulse_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pulse || snap_pulse) |=> !(clr_pulse || snap_pulse));
  p_ferr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ferr) |=> rx_err);
  p_clear_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |-> !rx_err);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  p_take_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trace_take |-> !tx_valid);
  p_take_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trace_take |=> (tx_valid && tx_data == $past(trace_pkt[31:24])));
endmodule

bind cmd_link cmd_link_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ferr(rx_ferr),
  .trace_take(trace_take), .trace_pkt(trace_pkt), .tx_data(tx_data),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .clr_pulse(clr_pulse),
  .snap_pulse(snap_pulse), .rx_err(rx_err)
);

// File: tb/tb_cmd_link.sv
module tb_cmd_link;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0, rx_ferr = 1'b0;
  logic trace_pending = 1'b0, trace_overflow = 1'b0;
  logic [7:0] event_count = 8'h11, drop_count = 8'h22;
  logic trace_req = 1'b0;
  logic [31:0] trace_pkt = 32'hE142_0781;
  logic trace_take, tx_valid, tx_ready = 1'b1;
  logic [7:0] tx_data, trace_mask, pat_a;
  logic [3:0] trace_div;
  logic arm, stream_en, clr_pulse, snap_pulse, rx_err;
  logic [2:0] pat_mode;
  logic [5:0] pat_div;

  cmd_link dut (.*);

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, nlog = 0;
  logic [7:0] log_b [64];
  bit done = 0;

  always @(posedge clk)
    if (rst_n && tx_valid && tx_ready && nlog < 64) begin
      log_b[nlog] <= tx_data;
      nlog <= nlog + 1;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic f = 1'b0);
    @(negedge clk);
    rx_data = b; rx_valid = 1'b1; rx_ferr = f;
    @(negedge clk);
    rx_valid = 1'b0; rx_ferr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_pkt(input string req, input int at, input logic [31:0] exp);
    chk(req, {log_b[at], log_b[at+1], log_b[at+2], log_b[at+3]}, exp);
  endtask

  // {command, argument, expected field value}
  localparam logic [23:0] VEC [8] = '{
    24'h10_5A_5A, 24'h11_F7_07, 24'h20_FD_05, 24'h21_FF_3F,
    24'h22_3C_3C, 24'h12_03_03, 24'h10_00_00, 24'h20_02_02 };

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R12 reset state
    chk("R12 mask", trace_mask, 0);
    chk("R12 modes", {pat_mode, pat_div, trace_div}, 0);
    chk("R12 flags", {arm, stream_en, rx_err, clr_pulse, snap_pulse, tx_valid}, 0);

    foreach (VEC[i]) begin
      logic [31:0] act;
      send(VEC[i][23:16]);
      send(VEC[i][15:8]);
      case (VEC[i][23:16])
        8'h10: act = trace_mask;
        8'h11: act = trace_div;
        8'h20: act = pat_mode;
        8'h21: act = pat_div;
        8'h22: act = pat_a;
        default: act = {arm, stream_en} == 2'b11 ? 3 : {stream_en, arm};
      endcase
      chk(VEC[i][23:16] == 8'h12 ? "R2 ctrl bits" : "R1 register write", act, VEC[i][7:0]);
    end
    idle(6);
    chk("R3 no ack bytes", nlog, 0);

    // R11 command code as argument
    send(8'h10); send(8'h30); idle(6);
    chk("R11 arg stored", trace_mask, 8'h30);
    chk("R11 no packet", nlog, 0);

    // R7 unknown byte ignored, next byte is a command
    send(8'h55); send(8'h20); send(8'h04); idle(4);
    chk("R7 mode after unknown", pat_mode, 4);
    chk("R7 no output", nlog, 0);

    // R4/R6 status, R5 ping
    trace_overflow = 1'b1;
    send(8'h30); idle(8);
    chk_pkt("R4 status packet R6", 0, 32'hA59C_1122);
    trace_pending = 1'b1;
    send(8'h31); idle(8);
    chk_pkt("R5 ping packet R6", 4, 32'hD754_01BC);
    trace_pending = 1'b0;

    // R8 framing error
    send(8'h31, 1'b1); idle(6);
    chk("R8 errored byte dropped", nlog, 8);
    chk("R8 sticky set", rx_err, 1);
    send(8'h20); send(8'h07, 1'b1); send(8'h05); idle(3);
    chk("R8 decoder reset by error", pat_mode, 4);
    send(8'h30); idle(8);
    chk_pkt("R8 status shows error R6", 8, 32'hA5DC_1122);
    send(8'h12);
    send(8'h0F);
    chk("R2 pulses high", {clr_pulse, snap_pulse}, 2'b11);
    chk("R8 sticky cleared", rx_err, 0);
    idle(1);
    chk("R2 pulses one cycle", {clr_pulse, snap_pulse}, 2'b00);
    chk("R2 arm stream held", {arm, stream_en}, 2'b11);

    // R9/R10 ordering under back-pressure
    tx_ready = 1'b0;
    send(8'h30); send(8'h31); idle(3);
    chk("R9 stalled nothing sent", nlog, 12);
    chk("R9 stalled head byte", {tx_valid, tx_data}, 9'h1A5);
    trace_req = 1'b1;
    idle(3);
    chk("R9 no take while busy", trace_take, 0);
    tx_ready = 1'b1;
    for (int k = 0; k < 50 && !trace_take; k++) @(negedge clk);
    @(negedge clk);
    trace_req = 1'b0;
    idle(16);
    chk_pkt("R9 status completes", 12, 32'hA59C_1122);
    chk_pkt("R10 trace before ping", 16, 32'hE142_0781);
    chk_pkt("R10 ping last", 20, 32'hD754_019C);
    chk("R9 total bytes", nlog, 24);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule